// File: doc/BRIEF.md
# Line Level Threshold Detector

This block watches one of two signed line measurements, a voltage sample and a current sample, each arriving with its own valid strobe. It takes the magnitude of the selected measurement and compares it with an unsigned threshold. It reports a crossing of that threshold in a programmable direction. A crossing sets a sticky event flag, which holds until software clears it with a write strobe. A separate enable gates the flag onto an interrupt request line.

A crossing is found by comparing two valid samples of the selected channel. The block remembers whether the previous valid sample lay above the threshold. When the new valid sample lands on the other side, in the chosen direction, that is an event. Reset forgets this history, and so does any change to the channel select or to the direction. The first sample seen after either can therefore never raise a false event.

Top module: `line_thresh_det`

## Requirements
- R1: After reset, `flag` and `irq` are low. No sample history is held, and the registered configuration is voltage channel with rising direction.
- R2: The magnitude is the absolute value of the two's-complement 8-bit sample, except that -128 (0x80) yields 127. A sample is "above" when its magnitude is strictly greater than the unsigned `thresh`.
- R3: With `sel_curr`=1 the block uses `curr_smp`/`curr_vld`; with `sel_curr`=0 it uses `volt_smp`/`volt_vld`. The unselected channel has no effect on `flag`.
- R4: With `dir_fall`=0, a valid sample that is above, following a retained valid sample that was not above, sets `flag` at that clock edge.
- R5: With `dir_fall`=1, a valid sample that is not above, following a retained valid sample that was above, sets `flag` at that clock edge.
- R6: The first valid sample after reset serves only as a reference and never sets `flag`.
- R7: In a cycle where `sel_curr` or `dir_fall` differs from its value at the previous edge, the history is discarded and that cycle's sample is dropped. The next valid sample is then only a reference.
- R8: `flag` stays set until an edge with `flag_clr` high and no event, which clears it. Without an event, `flag` never rises.
- R9: When an event and `flag_clr` occur at the same edge, `flag` ends up set.
- R10: `irq` equals `flag` AND `irq_en` combinationally. `irq_en` does not alter `flag`.
- R11: Cycles with the selected valid strobe low leave the history unchanged, whatever the sample value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| volt_smp | input | 8 | Signed line-voltage sample |
| volt_vld | input | 1 | Voltage sample valid strobe |
| curr_smp | input | 8 | Signed line-current sample |
| curr_vld | input | 1 | Current sample valid strobe |
| sel_curr | input | 1 | 1 = watch current, 0 = watch voltage |
| dir_fall | input | 1 | 1 = falling-below event, 0 = rising-above event |
| thresh | input | 8 | Unsigned threshold |
| flag_clr | input | 1 | Write strobe that clears the sticky flag |
| irq_en | input | 1 | Interrupt request enable |
| flag | output | 1 | Sticky crossing flag |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall on the same edge: a software clear of the flag and a fresh crossing. The bench provokes this directly by pulsing `flag_clr` together with the sample that completes a crossing, and expects the flag to stay set. The long sweep also drives periodic clears that land on random crossings, and a per-cycle model predicts the result. A second collision, a configuration change in the same cycle as a valid sample, is judged by checking that no event follows until two fresh valid samples have straddled the threshold.

// File: rtl/lt_pkg.sv
package lt_pkg;

  typedef enum logic {
    CH_VOLT = 1'b0,
    CH_CURR = 1'b1
  } lt_chan_e;

  typedef enum logic {
    DIR_RISE = 1'b0,
    DIR_FALL = 1'b1
  } lt_dir_e;

  // Retained relation of the last accepted sample to the threshold
  typedef struct packed {
    logic seen;
    logic above;
  } lt_hist_t;

  localparam int unsigned LT_NCH = 2;

endpackage

// File: rtl/lt_rst_sync.sv
module lt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/lt_magnitude.sv
module lt_magnitude #(
  parameter int unsigned SMP_W = 8
) (
  input  logic [SMP_W-1:0] smp_i,
  output logic [SMP_W-2:0] mag_o
);

  logic [SMP_W-1:0] negated;

  always_comb begin
    negated = {SMP_W{1'b0}} - smp_i;
    if (!smp_i[SMP_W-1]) begin
      mag_o = smp_i[SMP_W-2:0];
    end else if (smp_i[SMP_W-2:0] == '0) begin
      // most negative code saturates to the largest magnitude
      mag_o = '1;
    end else begin
      mag_o = negated[SMP_W-2:0];
    end
  end

endmodule

// File: rtl/lt_cross_track.sv
module lt_cross_track
  import lt_pkg::*;
#(
  parameter int unsigned SMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sel,
  input  logic             cfg_dir,
  input  logic             smp_vld,
  input  logic [SMP_W-2:0] smp_mag,
  input  logic [SMP_W-1:0] thresh,
  output logic             cross_evt
);

  logic     sel_q, sel_d;
  logic     dir_q, dir_d;
  logic     cfg_en;
  lt_hist_t hist_q, hist_d;
  logic     hist_en;
  logic     cfg_chg;
  logic     above_now;
  logic     rise_hit, fall_hit;

  always_comb begin
    cfg_chg   = (cfg_sel != sel_q) || (cfg_dir != dir_q);
    above_now = {1'b0, smp_mag} > thresh;
    sel_d     = cfg_sel;
    dir_d     = cfg_dir;
    cfg_en    = cfg_chg;

    hist_d  = hist_q;
    hist_en = cfg_chg || smp_vld;
    if (cfg_chg) begin
      hist_d.seen  = 1'b0;
      hist_d.above = 1'b0;
    end else if (smp_vld) begin
      hist_d.seen  = 1'b1;
      hist_d.above = above_now;
    end

    rise_hit  = !hist_q.above && above_now;
    fall_hit  = hist_q.above && !above_now;
    cross_evt = smp_vld && !cfg_chg && hist_q.seen &&
                ((cfg_dir == DIR_FALL) ? fall_hit : rise_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= CH_VOLT;
      dir_q <= DIR_RISE;
    end else if (cfg_en) begin
      sel_q <= sel_d;
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (hist_en) begin
      hist_q <= hist_d;
    end
  end

endmodule

// File: rtl/lt_flag_ctl.sv
module lt_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cross_evt,
  input  logic flag_clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);

  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = cross_evt || flag_clr;
    // a new crossing outranks a clear in the same cycle
    flag_d  = cross_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
  assign irq  = flag_q & irq_en;

endmodule

// File: rtl/line_thresh_det.sv
module line_thresh_det
  import lt_pkg::*;
#(
  parameter int unsigned SMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] volt_smp,
  input  logic             volt_vld,
  input  logic [SMP_W-1:0] curr_smp,
  input  logic             curr_vld,
  input  logic             sel_curr,
  input  logic             dir_fall,
  input  logic [SMP_W-1:0] thresh,
  input  logic             flag_clr,
  input  logic             irq_en,
  output logic             flag,
  output logic             irq
);

  localparam int unsigned MAG_W = SMP_W - 1;

  logic                          rst_sync_n;
  logic [LT_NCH-1:0][SMP_W-1:0]  smp_arr;
  logic [LT_NCH-1:0][MAG_W-1:0]  mag_arr;
  logic [LT_NCH-1:0]             vld_arr;
  logic [MAG_W-1:0]              mag_sel;
  logic                          vld_sel;
  logic                          cross_evt;

  lt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    smp_arr[CH_VOLT] = volt_smp;
    smp_arr[CH_CURR] = curr_smp;
    vld_arr[CH_VOLT] = volt_vld;
    vld_arr[CH_CURR] = curr_vld;
  end

  for (genvar ch = 0; ch < LT_NCH; ch++) begin : g_mag
    lt_magnitude #(.SMP_W(SMP_W)) u_mag (
      .smp_i (smp_arr[ch]),
      .mag_o (mag_arr[ch])
    );
  end

  always_comb begin
    mag_sel = mag_arr[sel_curr];
    vld_sel = vld_arr[sel_curr];
  end

  lt_cross_track #(.SMP_W(SMP_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_sel   (sel_curr),
    .cfg_dir   (dir_fall),
    .smp_vld   (vld_sel),
    .smp_mag   (mag_sel),
    .thresh    (thresh),
    .cross_evt (cross_evt)
  );

  lt_flag_ctl u_flag (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cross_evt (cross_evt),
    .flag_clr  (flag_clr),
    .irq_en    (irq_en),
    .flag      (flag),
    .irq       (irq)
  );

endmodule

// File: rtl/lt_det_chk.sv
module lt_det_chk #(
  parameter int unsigned SMP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SMP_W-1:0] volt_smp,
  input logic             volt_vld,
  input logic [SMP_W-1:0] curr_smp,
  input logic             curr_vld,
  input logic             sel_curr,
  input logic             dir_fall,
  input logic [SMP_W-1:0] thresh,
  input logic             flag_clr,
  input logic             irq_en,
  input logic             cross_evt,
  input logic             flag,
  input logic             irq
);

  function automatic logic is_above(input logic [SMP_W-1:0] s,
                                    input logic [SMP_W-1:0] t);
    int v;
    v = int'($signed(s));
    if (v < 0) v = -v;
    if (v > (2 ** (SMP_W - 1)) - 1) v = (2 ** (SMP_W - 1)) - 1;
    return v > int'(t);
  endfunction

  logic chk_vld, chk_above;
  always_comb begin
    chk_vld   = sel_curr ? curr_vld : volt_vld;
    chk_above = is_above(sel_curr ? curr_smp : volt_smp, thresh);
  end

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cross_evt |=> flag);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !cross_evt |=> !flag);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !flag && !cross_evt |=> !flag);

  a_r3_evt_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cross_evt |-> chk_vld);

  a_r4_rise_above: assert property (@(posedge clk) disable iff (!rst_n)
    cross_evt && !dir_fall |-> chk_above);

  a_r5_fall_below: assert property (@(posedge clk) disable iff (!rst_n)
    cross_evt && dir_fall |-> !chk_above);

  a_r7_cfg_change: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_curr != $past(sel_curr)) || (dir_fall != $past(dir_fall)) |-> !cross_evt);

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag && irq_en);

  a_r10_irq_driven: assert property (@(posedge clk) disable iff (!rst_n)
    flag && irq_en |-> irq);

endmodule

bind line_thresh_det lt_det_chk #(.SMP_W(SMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .volt_smp  (volt_smp),
  .volt_vld  (volt_vld),
  .curr_smp  (curr_smp),
  .curr_vld  (curr_vld),
  .sel_curr  (sel_curr),
  .dir_fall  (dir_fall),
  .thresh    (thresh),
  .flag_clr  (flag_clr),
  .irq_en    (irq_en),
  .cross_evt (cross_evt),
  .flag      (flag),
  .irq       (irq)
);

// File: tb/line_thresh_det_test.sv
`timescale 1ns/1ps
module line_thresh_det_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] volt_smp, curr_smp, thresh;
  logic       volt_vld, curr_vld, sel_curr, dir_fall, flag_clr, irq_en;
  logic       flag, irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench model state
  logic m_sel_q, m_dir_q, m_seen, m_above, m_flag;

  always #2.5 clk = ~clk;

  line_thresh_det uut (
    .clk(clk), .rst_n(rst_n),
    .volt_smp(volt_smp), .volt_vld(volt_vld),
    .curr_smp(curr_smp), .curr_vld(curr_vld),
    .sel_curr(sel_curr), .dir_fall(dir_fall), .thresh(thresh),
    .flag_clr(flag_clr), .irq_en(irq_en),
    .flag(flag), .irq(irq)
  );

  function automatic int magn(input logic [7:0] s);
    int v;
    v = int'($signed(s));
    if (v < 0) v = -v;
    if (v > 127) v = 127;
    return v;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sel_q = 1'b0; m_dir_q = 1'b0; m_seen = 1'b0; m_above = 1'b0; m_flag = 1'b0;
  endtask

  // one cycle: drive at negedge, update model at posedge, compare just after
  task automatic step(input logic [7:0] vs, input logic vv,
                      input logic [7:0] cs, input logic cv, input logic clr);
    logic chg, vld, ab, evt;
    string tag;
    volt_smp = vs; volt_vld = vv; curr_smp = cs; curr_vld = cv; flag_clr = clr;
    @(posedge clk);
    chg = (sel_curr != m_sel_q) || (dir_fall != m_dir_q);
    vld = sel_curr ? cv : vv;
    ab  = magn(sel_curr ? cs : vs) > int'(thresh);
    evt = vld && !chg && m_seen && (dir_fall ? (m_above && !ab) : (!m_above && ab));
    if (chg) m_seen = 1'b0;
    else if (vld) begin m_seen = 1'b1; m_above = ab; end
    m_sel_q = sel_curr; m_dir_q = dir_fall;
    if (evt) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
    if (evt && clr) tag = "R9";
    else if (evt) tag = dir_fall ? "R5" : "R4";
    else if (clr) tag = "R8";
    else tag = "R11";
    #1;
    check(flag, m_flag, tag);
    check(irq, m_flag && irq_en, "R10");
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic idle();
    step(8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  // set configuration and force a fresh history, then clear the flag
  task automatic fresh(input logic s, input logic d, input logic [7:0] t);
    sel_curr = s; dir_fall = ~d; thresh = t;
    idle();
    dir_fall = d;
    idle();
    step(8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    volt_smp = 8'h00; curr_smp = 8'h00; volt_vld = 1'b0; curr_vld = 1'b0;
    sel_curr = 1'b0; dir_fall = 1'b0; thresh = 8'd50; flag_clr = 1'b0; irq_en = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(flag, 1'b0, "R1");
    check(irq, 1'b0, "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(flag, 1'b0, "R1");

    // R6: first sample after reset is only a reference
    step(8'd100, 1'b1, 8'h00, 1'b0, 1'b0);
    check(flag, 1'b0, "R6");
    step(8'd20, 1'b1, 8'h00, 1'b0, 1'b0);
    step(8'd100, 1'b1, 8'h00, 1'b0, 1'b0);
    check(flag, 1'b1, "R4");

    // R2: saturation of the most negative code and negative magnitudes
    fresh(1'b0, 1'b0, 8'd126);
    step(8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
    step(8'h80, 1'b1, 8'h00, 1'b0, 1'b0);
    check(flag, 1'b1, "R2");
    fresh(1'b0, 1'b0, 8'd127);
    step(8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
    step(8'h80, 1'b1, 8'h00, 1'b0, 1'b0);
    check(flag, 1'b0, "R2");
    fresh(1'b1, 1'b0, 8'd40);
    step(8'h00, 1'b0, 8'd10, 1'b1, 1'b0);
    step(8'h00, 1'b0, 8'hD7, 1'b1, 1'b0);   // -41
    check(flag, 1'b1, "R2");

    // R3: unselected channel ignored
    fresh(1'b1, 1'b0, 8'd50);
    step(8'h00, 1'b0, 8'd10, 1'b1, 1'b0);
    step(8'd100, 1'b1, 8'd10, 1'b0, 1'b0);
    check(flag, 1'b0, "R3");
    step(8'h00, 1'b1, 8'd100, 1'b1, 1'b0);
    check(flag, 1'b1, "R3");

    // R11 and R5: invalid cycles leave history, falling event
    fresh(1'b0, 1'b1, 8'd50);
    step(8'd100, 1'b1, 8'h00, 1'b0, 1'b0);
    step(8'd10, 1'b0, 8'h00, 1'b0, 1'b0);
    check(flag, 1'b0, "R11");
    step(8'd10, 1'b1, 8'h00, 1'b0, 1'b0);
    check(flag, 1'b1, "R5");

    // R7: sample in the config-change cycle is dropped
    fresh(1'b0, 1'b0, 8'd50);
    step(8'd10, 1'b1, 8'h00, 1'b0, 1'b0);
    sel_curr = 1'b1;
    step(8'h00, 1'b0, 8'd100, 1'b1, 1'b0);
    check(flag, 1'b0, "R7");
    step(8'h00, 1'b0, 8'd100, 1'b1, 1'b0);
    check(flag, 1'b0, "R7");
    step(8'h00, 1'b0, 8'd10, 1'b1, 1'b0);
    step(8'h00, 1'b0, 8'd100, 1'b1, 1'b0);
    check(flag, 1'b1, "R7");

    // R9: event and clear in the same cycle
    fresh(1'b0, 1'b0, 8'd50);
    step(8'd10, 1'b1, 8'h00, 1'b0, 1'b0);
    step(8'd100, 1'b1, 8'h00, 1'b0, 1'b1);
    check(flag, 1'b1, "R9");
    idle();
    check(flag, 1'b1, "R8");
    step(8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
    check(flag, 1'b0, "R8");

    // R10: enable gates the request, not the flag
    fresh(1'b0, 1'b0, 8'd50);
    step(8'd10, 1'b1, 8'h00, 1'b0, 1'b0);
    irq_en = 1'b0;
    step(8'd100, 1'b1, 8'h00, 1'b0, 1'b0);
    check(flag, 1'b1, "R10");
    check(irq, 1'b0, "R10");
    irq_en = 1'b1;
    #1;
    check(irq, 1'b1, "R10");

    // near-exhaustive sweep over channel, direction and thresholds
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 2; d++) begin
        for (int ti = 0; ti < 8; ti++) begin
          sel_curr = s[0];
          dir_fall = d[0];
          case (ti)
            0: thresh = 8'd0;   1: thresh = 8'd1;   2: thresh = 8'd63;  3: thresh = 8'd100;
            4: thresh = 8'd126; 5: thresh = 8'd127; 6: thresh = 8'd128; default: thresh = 8'd255;
          endcase
          for (int k = 0; k < 200; k++) begin
            irq_en = (k % 13) < 7;
            step(8'(k * 37 + ti * 19 + d * 11), (k % 5) != 3,
                 8'(k * 53 + 5 + ti), (k % 4) != 1, (k % 9) == 0);
          end
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule